// File: doc/BRIEF.md
# Table-Select PSK Modulator

This block produces a sampled BPSK or QPSK carrier with no multiplier or adder in its signal path. It holds four constant tables. Each table contains one full carrier period, and each is shifted to one of the four QPSK phases. A single free-running address counter reads all four tables at the same index. The phase for each symbol comes from a 4:1 selection among the table outputs. No mixing takes place.

Serial data enters one bit per strobe. In QPSK mode the bits are paired: the first bit of a pair is the odd bit and the second is the even bit. In BPSK mode each bit alone chooses between two tables that lie 180° apart. The selection is loaded only at a symbol boundary, so every symbol is a whole number of clean carrier periods.

Top module: `qpsk_rom_modulator`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sample_out` becomes 0, the address counter goes to 0, the phase selection goes to pair 00 and any half-received pair is discarded.
- R2: The address counter advances by one each clock and wraps from 63 back to 0. `sample_out` is registered, so it shows the table entry for address k one clock after the counter held k.
- R3: Table entry j (0..63) of the base carrier is computed as follows. Let u = j mod 32 and p = u*(32-u). The magnitude is m = floor(508*p/(1280-p)). The entry is +m for j < 32 and -m otherwise. It is an 8-bit two's complement value.
- R4: In QPSK mode the pair (odd bit first, taken as the MSB) maps to a phase as follows: 00 gives 225° (base index offset 40), 01 gives 315° (offset 56), 10 gives 135° (offset 24) and 11 gives 45° (offset 8). Sample k of a symbol is base entry (k+offset) mod 64.
- R5: The selection changes only at a symbol boundary, which is the clock at which the counter leaves 63 on the last wrap of a symbol. A pair that completes part-way through a symbol does not alter that symbol's samples.
- R6: If no complete pair has arrived since reset or since the previous boundary, the next symbol repeats the previous pair's phase.
- R7: In BPSK mode each strobed bit b becomes the pair {b,b}: 0 gives the 225° table and 1 gives the 45° table. BPSK mode also clears any half-received QPSK pair.
- R8: In QPSK mode a lone odd bit waits for its even partner, and the two may arrive in different symbols. The pair takes effect at the first boundary after it completes.
- R9: If two complete pairs arrive within one symbol, the later one is used at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qpsk_en | input | 1 | 1 = QPSK (bit pairs), 0 = BPSK (single bits) |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Strobe: `bit_in` is taken at this clock edge |
| sample_out | output | 8 | Signed carrier sample |

## Verification
The assertions assume that reset is low from time zero for at least one clock. Beyond that they place no limit on how often strobes arrive. They check that the counter steps by one, that the selection moves only at a boundary and loads the pending pair there, and that BPSK pairs are symmetric. The directed stimulus changes `qpsk_en` only at a symbol boundary. It finishes every strobe before the counter's last address, so that each expected pair belongs to a known symbol. All 64 samples of every symbol are compared with tables computed from the formula in R3.

// File: rtl/qpsk_pkg.sv
// Shared constants and elaboration-time helpers for the table-select modulator.
// Assumes a power-of-two period of at least 8 samples.
package qpsk_pkg;

    typedef logic [1:0] pair_t;

    // Signed carrier value at index idx of an n-sample period, peak amp.
    // Uses a rational half-sine approximation computed at elaboration.
    function automatic int carrier_at(input int idx, input int n, input int amp);
        int h;
        int j;
        int u;
        int p;
        int mag;
        h   = n / 2;
        j   = idx % n;
        u   = (j >= h) ? (j - h) : j;
        p   = u * (h - u);
        mag = (4 * amp * p) / ((5 * h * h) / 4 - p);
        return (j >= h) ? -mag : mag;
    endfunction

    // Index offset of each selectable phase: 00=225, 01=315, 10=135, 11=45 deg.
    function automatic int phase_offset(input int sel, input int n);
        case (sel)
            0:       return (5 * n) / 8;
            1:       return (7 * n) / 8;
            2:       return (3 * n) / 8;
            default: return n / 8;
        endcase
    endfunction

endpackage

// File: rtl/qpsk_bit_splitter.sv
// Splits the serial stream into odd/even pairs (QPSK) or doubles each bit (BPSK).
// Holds the most recent complete pair until the next one overwrites it.
module qpsk_bit_splitter
    import qpsk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  qpsk_en,
    input  logic  bit_in,
    input  logic  bit_vld,
    output pair_t pair_pend
);

    logic half_q;
    logic odd_q;

    // Capture bits into the pending pair register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q    <= 1'b0;
            odd_q     <= 1'b0;
            pair_pend <= 2'b00;
        end else if (!qpsk_en) begin
            half_q <= 1'b0;
            if (bit_vld) pair_pend <= {bit_in, bit_in};
        end else if (bit_vld) begin
            if (!half_q) begin
                odd_q  <= bit_in;
                half_q <= 1'b1;
            end else begin
                pair_pend <= {odd_q, bit_in};
                half_q    <= 1'b0;
            end
        end
    end

    AST_BPSK_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
        (!qpsk_en && bit_vld) |=> (pair_pend[1] == pair_pend[0])); // R7
    AST_BPSK_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        !qpsk_en |=> !half_q); // R7

endmodule

// File: rtl/qpsk_phase_clock.sv
// Free-running table address counter with a symbol-boundary pulse.
// A symbol is WRAPS counter periods; sym_end is high in its final cycle.
module qpsk_phase_clock #(
    parameter int ADDR_W = 6,
    parameter int WRAPS  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] addr,
    output logic              sym_end
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    logic at_last;

    // Advance the shared table address every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) addr <= '0;
        else        addr <= addr + 1'b1;
    end

    assign at_last = (addr == LAST_ADDR);

    generate
        if (WRAPS > 1) begin : g_multi
            localparam int WCNT_W = $clog2(WRAPS);
            localparam logic [WCNT_W-1:0] LAST_WRAP = WCNT_W'(WRAPS - 1);
            logic [WCNT_W-1:0] wrap_q;
            // Count completed periods within the current symbol.
            always_ff @(posedge clk) begin
                if (!rst_n)       wrap_q <= '0;
                else if (at_last) wrap_q <= (wrap_q == LAST_WRAP) ? '0 : wrap_q + 1'b1;
            end
            assign sym_end = at_last && (wrap_q == LAST_WRAP);
        end else begin : g_single
            assign sym_end = at_last;
        end
    endgenerate

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (addr == $past(addr) + 1'b1)); // R2

endmodule

// File: rtl/qpsk_phase_rom.sv
// One constant carrier table, shifted by OFFSET samples, read combinationally.
// Contents come from the package formula at elaboration; no memory file.
module qpsk_phase_rom
    import qpsk_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int SAMPLE_W = 8,
    parameter int OFFSET   = 0
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [SAMPLE_W-1:0] data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;

    logic [SAMPLE_W-1:0] table_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            assign table_q[i] = SAMPLE_W'(carrier_at(i + OFFSET, DEPTH, AMP));
        end
    endgenerate

    assign data = table_q[addr];

endmodule

// File: rtl/qpsk_rom_modulator.sv
// Top: four phase tables read in parallel, one selected per symbol, output registered.
// Assumes qpsk_en changes only between symbols for clean pairing.
module qpsk_rom_modulator
    import qpsk_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int SAMPLE_W = 8,
    parameter int WRAPS    = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       qpsk_en,
    input  logic                       bit_in,
    input  logic                       bit_vld,
    output logic signed [SAMPLE_W-1:0] sample_out
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0]   addr;
    logic                sym_end;
    pair_t               pair_pend;
    pair_t               sel_q;
    logic [SAMPLE_W-1:0] rom_data [4];

    qpsk_phase_clock #(.ADDR_W(ADDR_W), .WRAPS(WRAPS)) u_clock (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .sym_end (sym_end)
    );

    qpsk_bit_splitter u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .qpsk_en   (qpsk_en),
        .bit_in    (bit_in),
        .bit_vld   (bit_vld),
        .pair_pend (pair_pend)
    );

    generate
        for (genvar g = 0; g < 4; g++) begin : g_rom
            qpsk_phase_rom #(
                .ADDR_W   (ADDR_W),
                .SAMPLE_W (SAMPLE_W),
                .OFFSET   (phase_offset(g, DEPTH))
            ) u_rom (
                .addr (addr),
                .data (rom_data[g])
            );
        end
    endgenerate

    // Load the symbol's table selection only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= 2'b00;
        else if (sym_end) sel_q <= pair_pend;
    end

    // Register the selected table entry onto the output.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_out <= '0;
        else        sample_out <= $signed(rom_data[sel_q]);
    end

    AST_SEL_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_end |=> $stable(sel_q)); // R5
    AST_SEL_TAKES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        sym_end |=> (sel_q == $past(pair_pend))); // R6

endmodule

// File: tb/tb_qpsk_rom_modulator.sv
// Directed bench: each scenario task covers whole symbols and checks every sample.
module tb_qpsk_rom_modulator;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              qpsk_en = 1'b1;
    logic              bit_in = 1'b0;
    logic              bit_vld = 1'b0;
    logic signed [7:0] sample_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cur_sel;
    int pend;
    int half;
    int odd_b;

    always #2 clk = ~clk;

    qpsk_rom_modulator dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .qpsk_en    (qpsk_en),
        .bit_in     (bit_in),
        .bit_vld    (bit_vld),
        .sample_out (sample_out)
    );

    // Expected sample k of pair s, built from the R3/R4 rules.
    function automatic int ref_sample(input int s, input int k);
        int ofs;
        int j;
        int u;
        int q;
        int m;
        ofs = (s == 0) ? 40 : (s == 1) ? 56 : (s == 2) ? 24 : 8;
        j = (k + ofs) & 63;
        u = j % 32;
        q = u * (32 - u);
        m = (508 * q) / (1280 - q);
        return (j < 32) ? m : -m;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Model of the splitter, applied when a bit is strobed.
    task automatic model_bit(input bit mode, input bit b);
        if (!mode) begin
            half = 0;
            pend = {30'd0, b, b};
        end else if (half == 0) begin
            odd_b = b;
            half = 1;
        end else begin
            pend = odd_b * 2 + b;
            half = 0;
        end
    endtask

    // One symbol: strobe nb bits from tick 'at', compare all 64 samples.
    task automatic run_symbol(input string req, input bit mode, input int nb,
                              input bit [3:0] bits, input int at);
        qpsk_en = mode;
        if (!mode) half = 0;
        for (int k = 0; k < 64; k++) begin
            if (k >= at && k < at + nb) begin
                bit_vld = 1'b1;
                bit_in  = bits[k - at];
                model_bit(mode, bits[k - at]);
            end else begin
                bit_vld = 1'b0;
                bit_in  = 1'b0;
            end
            @(negedge clk);
            check(req, int'(sample_out), ref_sample(cur_sel, k));
        end
        bit_vld = 1'b0;
        cur_sel = pend;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 reset output", int'(sample_out), 0);
        end
        rst_n = 1'b1;
        cur_sel = 0; pend = 0; half = 0; odd_b = 0;
    endtask

    task automatic t_qpsk_all_pairs;
        run_symbol("R2 R3 first symbol", 1'b1, 2, 4'b0010, 3);  // sends 0,1
        run_symbol("R4 pair 01", 1'b1, 2, 4'b0001, 5);          // sends 1,0
        run_symbol("R4 pair 10", 1'b1, 2, 4'b0011, 0);          // sends 1,1
        run_symbol("R4 pair 11", 1'b1, 2, 4'b0000, 10);         // sends 0,0
        run_symbol("R4 pair 00", 1'b1, 0, 4'b0000, 0);
    endtask

    task automatic t_late_and_hold;
        run_symbol("R5 late pair", 1'b1, 2, 4'b0011, 61);
        run_symbol("R5 late pair applied", 1'b1, 0, 4'b0000, 0);
        run_symbol("R6 repeat phase", 1'b1, 0, 4'b0000, 0);
    endtask

    task automatic t_split_pair;
        run_symbol("R8 odd only", 1'b1, 1, 4'b0000, 20);
        run_symbol("R8 even later", 1'b1, 1, 4'b0001, 30);
        run_symbol("R8 pair 01 used", 1'b1, 0, 4'b0000, 0);
    endtask

    task automatic t_two_pairs;
        run_symbol("R9 two pairs", 1'b1, 4, 4'b0110, 8);        // pairs 01 then 10
        run_symbol("R9 later pair used", 1'b1, 0, 4'b0000, 0);
    endtask

    task automatic t_bpsk;
        run_symbol("R7 bpsk one", 1'b1, 1, 4'b0001, 4);         // half pair left
        run_symbol("R7 bpsk bit 1", 1'b0, 1, 4'b0001, 4);
        run_symbol("R7 bpsk bit 0", 1'b0, 1, 4'b0000, 40);
        run_symbol("R7 bpsk to qpsk", 1'b0, 0, 4'b0000, 0);
        run_symbol("R7 half cleared", 1'b1, 1, 4'b0001, 2);
        run_symbol("R7 after clear", 1'b1, 0, 4'b0000, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_qpsk_all_pairs();
        t_late_and_hold();
        t_split_pair();
        t_two_pairs();
        t_bpsk();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule